// File: doc/BRIEF.md
# Host Reset Request Register

This block is a memory-mapped control and status register. A host uses it to ask an embedded I/O processor for a reset, and the block sits between the host bus window, the internal bus window and that processor. It holds two one-bit requests:

- a firmware (selective) reset request;
- a multi-function (coordinated) reset request, which is honoured only when a capability flag in a companion outbound register is set.

A single request raises a level interrupt to the local processor. A host write that sets both requests at once, with the capability present, does not interrupt. It starts an internal bus reset pulse straight away and logs that cause in a sticky cause flag, which local software can read and clear.

The host side sees the request bits as read/write. The local processor sees them as read-clear. Every pin is a plain control or status signal. The bus ports carry single-word register accesses, with no valid/ready flow and no back-pressure, and each access completes in the cycle it is presented.

Top module: `host_rst_req_reg`

## Requirements
- R1: After reset, both request bits, the interrupt, the bus reset output and the cause flag are 0. Bits 31:2 of every register read return 0.
- R2: A host write to offset 0x38 with data bit 0 = 1 and bit 1 = 0 sets the firmware request (bit 0). The interrupt output then goes high one cycle later and stays high as a level, and the bus reset output stays low.
- R3: A host write with only bit 1 = 1 sets the coordinated request (bit 1) and raises the interrupt when companion input bit 1 is 1. When companion bit 1 is 0, bit 1 of the write is dropped and leaves no trace.
- R4: A host write with bits 1:0 = 11 while companion bit 1 is 1 starts the bus reset pulse on the next cycle. The interrupt stays low and both request bits read 0. When companion bit 1 is 0, the same write acts as a firmware-only request.
- R5: A host read at offset 0x38 returns the request bits in the same cycle. A host write replaces them, so writing 00 clears both.
- R6: A local read at offset 0x4038 returns the request bits in the same cycle and clears them at the next edge. The interrupt then drops.
- R7: When a host write at 0x38 and a local read-clear at 0x4038 fall in the same cycle, the host write value is kept.
- R8: The bus reset output stays high for exactly 16 cycles. The request bits are held at 0 and host writes to 0x38 are ignored while it is high.
- R9: The cause flag is set when the pulse starts. It reads as bit 0 at local offset 0x403C and stays set until a local write to 0x403C with data bit 0 = 1. A local write with bit 0 = 0 leaves it set.
- R10: Accesses at any other offset change nothing. A local read at another offset does not clear the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host access is a write (1) or a read (0) |
| host_addr | input | 16 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, same cycle |
| lcl_rd | input | 1 | Local processor read strobe |
| lcl_wr | input | 1 | Local processor write strobe |
| lcl_addr | input | 16 | Local byte offset |
| lcl_wdata | input | 32 | Local write data |
| lcl_rdata | output | 32 | Local read data, same cycle |
| ob_reset_ctrl | input | 32 | Companion outbound register; bit 1 is the multi-function capability flag |
| irq_out | output | 1 | Level interrupt to the local processor |
| ibus_rst_out | output | 1 | Internal bus reset pulse, active high |

## Verification
Read data is combinational, so the bench samples it 1 ns after driving the address, within the same cycle. The interrupt, the start of the bus reset and the read-clear each come from one register and show one edge after the access edge. The bench drives every access on a falling edge and checks at the next falling edge. The bus reset length is measured by counting falling edges from the first one at which the pulse is high, and 16 is expected. For the same-cycle conflict case, the host write and the local read are driven in one cycle.

// File: rtl/rstreq_pkg.sv
package rstreq_pkg;
  localparam int SR_POS    = 0;
  localparam int CR_POS    = 1;
  localparam int MFCAP_POS = 1;
  localparam int CAUSE_POS = 0;

  typedef struct packed {
    logic cr;
    logic sr;
  } req_t;

  typedef struct packed {
    logic host_wr;
    logic host_rd;
    logic lcl_rd;
    logic cause_rd;
    logic cause_wr;
  } hit_t;
endpackage

// File: rtl/rstreq_decode.sv
module rstreq_decode #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] HOST_OFS  = 16'h0038,
  parameter logic [15:0] LCL_OFS   = 16'h4038,
  parameter logic [15:0] CAUSE_OFS = 16'h403C
) (
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              lcl_rd,
  input  logic              lcl_wr,
  input  logic [ADDR_W-1:0] lcl_addr,
  output rstreq_pkg::hit_t  hit
);
  logic host_match, lcl_match, cause_match;

  assign host_match  = (host_addr == HOST_OFS[ADDR_W-1:0]);
  assign lcl_match   = (lcl_addr == LCL_OFS[ADDR_W-1:0]);
  assign cause_match = (lcl_addr == CAUSE_OFS[ADDR_W-1:0]);

  always_comb begin
    hit.host_wr  = host_sel & host_wr & host_match;
    hit.host_rd  = host_sel & ~host_wr & host_match;
    hit.lcl_rd   = lcl_rd & lcl_match;
    hit.cause_rd = lcl_rd & cause_match;
    hit.cause_wr = lcl_wr & cause_match;
  end
endmodule

// File: rtl/rstreq_bits.sv
module rstreq_bits (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  rstreq_pkg::req_t  wbits,
  input  logic              mf_cap,
  input  logic              rd_clr,
  input  logic              busy,
  output rstreq_pkg::req_t  q,
  output logic              start_rst
);
  logic both;

  assign both      = wbits.sr & wbits.cr & mf_cap;
  assign start_rst = wr_hit & ~busy & both;

  always_ff @(posedge clk) begin
    if (!rst_n || busy) begin
      q <= '0;
    end else if (wr_hit) begin
      if (both) begin
        q <= '0;
      end else begin
        q.sr <= wbits.sr;
        q.cr <= wbits.cr & mf_cap;
      end
    end else if (rd_clr) begin
      q <= '0;
    end
  end
endmodule

// File: rtl/rstreq_busrst.sv
module rstreq_busrst #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cause_clr,
  output logic busy,
  output logic cause_q
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CNT_W'(PULSE_CYCLES);
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
    end else if (start) begin
      cause_q <= 1'b1;
    end else if (cause_clr) begin
      cause_q <= 1'b0;
    end
  end
endmodule

// File: rtl/host_rst_req_reg.sv
module host_rst_req_reg #(
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 16,
  parameter int          PULSE_CYCLES = 16,
  parameter logic [15:0] HOST_OFS     = 16'h0038,
  parameter logic [15:0] LCL_OFS      = 16'h4038,
  parameter logic [15:0] CAUSE_OFS    = 16'h403C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              lcl_rd,
  input  logic              lcl_wr,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic [DATA_W-1:0] lcl_wdata,
  output logic [DATA_W-1:0] lcl_rdata,
  input  logic [DATA_W-1:0] ob_reset_ctrl,
  output logic              irq_out,
  output logic              ibus_rst_out
);
  import rstreq_pkg::*;

  localparam int PAD_W = DATA_W - 2;

  hit_t hit;
  req_t wbits;
  req_t req_q;
  logic mf_cap, start_rst, busy, cause_q, cause_clr;
  logic unused_bits;

  assign wbits.sr    = host_wdata[SR_POS];
  assign wbits.cr    = host_wdata[CR_POS];
  assign mf_cap      = ob_reset_ctrl[MFCAP_POS];
  assign cause_clr   = hit.cause_wr & lcl_wdata[CAUSE_POS];
  assign unused_bits = ^{host_wdata, lcl_wdata, ob_reset_ctrl};

  rstreq_decode #(
    .ADDR_W(ADDR_W), .HOST_OFS(HOST_OFS), .LCL_OFS(LCL_OFS), .CAUSE_OFS(CAUSE_OFS)
  ) u_decode (
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .lcl_rd(lcl_rd), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr), .hit(hit)
  );

  rstreq_bits u_bits (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit.host_wr), .wbits(wbits),
    .mf_cap(mf_cap), .rd_clr(hit.lcl_rd), .busy(busy),
    .q(req_q), .start_rst(start_rst)
  );

  rstreq_busrst #(.PULSE_CYCLES(PULSE_CYCLES)) u_busrst (
    .clk(clk), .rst_n(rst_n), .start(start_rst), .cause_clr(cause_clr),
    .busy(busy), .cause_q(cause_q)
  );

  always_comb begin
    host_rdata = '0;
    if (hit.host_rd) host_rdata = {{PAD_W{1'b0}}, req_q};
  end

  always_comb begin
    lcl_rdata = '0;
    if (hit.lcl_rd)        lcl_rdata = {{PAD_W{1'b0}}, req_q};
    else if (hit.cause_rd) lcl_rdata[CAUSE_POS] = cause_q;
  end

  assign irq_out      = req_q.sr | req_q.cr;
  assign ibus_rst_out = busy;
endmodule

// File: rtl/rstreq_checker.sv
module rstreq_checker #(
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 16,
  parameter int          PULSE_CYCLES = 16,
  parameter logic [15:0] HOST_OFS     = 16'h0038,
  parameter logic [15:0] LCL_OFS      = 16'h4038
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [1:0]        host_wbits,
  input logic [DATA_W-1:0] host_rdata,
  input logic              lcl_rd,
  input logic [ADDR_W-1:0] lcl_addr,
  input logic              mf_cap,
  input logic              irq_out,
  input logic              ibus_rst_out,
  input logic              cause_q
);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2);

  logic [RUN_W-1:0] run_len;
  logic hwr, lclr;

  assign hwr  = host_sel & host_wr & (host_addr == HOST_OFS[ADDR_W-1:0]);
  assign lclr = lcl_rd & (lcl_addr == LCL_OFS[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)            run_len <= '0;
    else if (ibus_rst_out) run_len <= run_len + 1'b1;
    else                   run_len <= '0;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[DATA_W-1:2] == '0);

  assert_sr_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr && host_wbits == 2'b01 && !ibus_rst_out) |=> (irq_out && !ibus_rst_out));

  assert_cr_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr && host_wbits == 2'b10 && !mf_cap && !ibus_rst_out) |=> !irq_out);

  assert_both_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr && host_wbits == 2'b11 && mf_cap && !ibus_rst_out) |=> (ibus_rst_out && !irq_out));

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lclr && !hwr) |=> !irq_out);

  assert_host_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lclr && hwr && host_wbits == 2'b01 && !ibus_rst_out) |=> irq_out);

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibus_rst_out) |-> (run_len == RUN_W'(PULSE_CYCLES)));

  assert_no_irq_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ibus_rst_out |-> !irq_out);

  assert_cause_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibus_rst_out) |-> cause_q);
endmodule

bind host_rst_req_reg rstreq_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PULSE_CYCLES(PULSE_CYCLES),
  .HOST_OFS(HOST_OFS), .LCL_OFS(LCL_OFS)
) u_rstreq_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_addr(host_addr), .host_wbits(host_wdata[1:0]), .host_rdata(host_rdata),
  .lcl_rd(lcl_rd), .lcl_addr(lcl_addr), .mf_cap(ob_reset_ctrl[1]),
  .irq_out(irq_out), .ibus_rst_out(ibus_rst_out), .cause_q(cause_q)
);

// File: tb/test_host_rst_req_reg.sv
module test_host_rst_req_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] H_OFS = 16'h0038;
  localparam logic [15:0] L_OFS = 16'h4038;
  localparam logic [15:0] C_OFS = 16'h403C;
  // {mf, wbits[1:0], exp_irq, exp_rst, exp_rd[1:0]}
  localparam int NVEC = 7;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1_01_1_0_01, 7'b1_10_1_0_10, 7'b1_11_0_1_00, 7'b0_10_0_0_00,
    7'b0_11_1_0_01, 7'b1_00_0_0_00, 7'b0_01_1_0_01 };

  logic clk = 0, rst_n = 0;
  logic host_sel = 0, host_wr = 0, lcl_rd = 0, lcl_wr = 0;
  logic [15:0] host_addr = '0, lcl_addr = '0;
  logic [31:0] host_wdata = '0, lcl_wdata = '0, ob_reset_ctrl = '0;
  logic [31:0] host_rdata, lcl_rdata;
  logic irq_out, ibus_rst_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_rst_req_reg i_host_rst_req_reg (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lcl_rd(lcl_rd), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
    .lcl_rdata(lcl_rdata), .ob_reset_ctrl(ob_reset_ctrl),
    .irq_out(irq_out), .ibus_rst_out(ibus_rst_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic hwr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_sel = 0; host_wr = 0;
  endtask

  task automatic hrd(logic [15:0] a, output logic [31:0] v);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 v = host_rdata;
    host_sel = 0;
  endtask

  task automatic lrd(logic [15:0] a, output logic [31:0] v);
    lcl_rd = 1; lcl_addr = a;
    #1 v = lcl_rdata;
    @(negedge clk); lcl_rd = 0;
  endtask

  task automatic lwr(logic [15:0] a, logic [31:0] d);
    lcl_wr = 1; lcl_addr = a; lcl_wdata = d;
    @(negedge clk); lcl_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1: reset state
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 busrst", 32'(ibus_rst_out), 0);
    hrd(H_OFS, v); chk("R1 host rd", v, 0);
    lrd(C_OFS, v); chk("R1 cause", v, 0);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      ob_reset_ctrl = {30'b0, VEC[i][6], 1'b0};
      hwr(H_OFS, {30'b0, VEC[i][5:4]});
      chk("R2/R3/R4 irq", 32'(irq_out), 32'(VEC[i][3]));
      chk("R4 busrst", 32'(ibus_rst_out), 32'(VEC[i][2]));
      hrd(H_OFS, v); chk("R5 readback", v, {30'b0, VEC[i][1:0]});
    end

    // R5: writing zeros clears; reserved bits read 0 (R1)
    do_reset(); ob_reset_ctrl = 32'h2;
    hwr(H_OFS, 32'hFFFF_FFFD);
    hrd(H_OFS, v); chk("R1 reserved zero", v, 32'h1);
    hwr(H_OFS, 32'h0);
    chk("R5 write zero clears", 32'(irq_out), 0);

    // R6: local read-clear
    hwr(H_OFS, 32'h1);
    lrd(L_OFS, v); chk("R6 local read value", v, 32'h1);
    chk("R6 irq dropped", 32'(irq_out), 0);
    hrd(H_OFS, v); chk("R6 cleared", v, 0);

    // R10: other offsets
    hwr(16'h003C, 32'h1); chk("R10 host bad addr", 32'(irq_out), 0);
    hwr(L_OFS, 32'h1);    chk("R10 host local ofs", 32'(irq_out), 0);
    hwr(H_OFS, 32'h1);
    lrd(16'h4000, v);     chk("R10 local bad addr no clear", 32'(irq_out), 1);

    // R7: host write wins over same-cycle read-clear
    hwr(H_OFS, 32'h2);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = H_OFS; host_wdata = 32'h1;
    lcl_rd = 1; lcl_addr = L_OFS;
    @(negedge clk);
    host_sel = 0; host_wr = 0; lcl_rd = 0;
    hrd(H_OFS, v); chk("R7 host wins", v, 32'h1);
    chk("R7 irq", 32'(irq_out), 1);

    // R8, R9: pulse length and cause flag
    hwr(H_OFS, 32'h3);
    begin
      int cnt = 0;
      while (ibus_rst_out && cnt < 100) begin cnt++; @(negedge clk); end
      chk("R8 pulse length", 32'(cnt), 16);
    end
    chk("R8 bits cleared irq", 32'(irq_out), 0);
    hrd(H_OFS, v); chk("R8 bits cleared", v, 0);
    lrd(C_OFS, v); chk("R9 cause set", v, 1);
    lwr(C_OFS, 32'h0);
    lrd(C_OFS, v); chk("R9 write 0 keeps", v, 1);
    lwr(C_OFS, 32'h1);
    lrd(C_OFS, v); chk("R9 write 1 clears", v, 0);

    // R8: host write during pulse ignored
    hwr(H_OFS, 32'h3);
    hwr(H_OFS, 32'h1);
    chk("R8 pulse still high", 32'(ibus_rst_out), 1);
    begin
      int cnt = 0;
      while (ibus_rst_out && cnt < 100) begin cnt++; @(negedge clk); end
    end
    chk("R8 write ignored irq", 32'(irq_out), 0);
    hrd(H_OFS, v); chk("R8 write ignored bits", v, 0);

    finish_run();
  end
endmodule